// File: doc/BRIEF.md
# Multicarrier Level-Shifted PWM Modulator

This block drives the gates of a single-phase five-level hybrid inverter. The inverter has a three-level switching cell that sets the output magnitude (0, E or 2E) and a polarity H-bridge that sets the sign. A sampled sinusoidal reference is first scaled by a modulation index. It is then compared against four triangular carriers, one per band, stacked between negative and positive full scale. The number of carriers that the reference exceeds gives the output level, from -2 to +2.

A two-bit disposition input sets the carrier phase relationship. The carriers can all run in phase, the lower pair can be mirrored against the upper pair, or each carrier can be mirrored against its neighbour. All four carriers come from one up/down sample counter. A mirrored carrier is formed by subtracting the count from the peak.

The cell legs switch at carrier rate. The two bridge legs change only at the fundamental rate, and only while the cell holds the output at zero. Every leg is driven as a complementary high/low pair with a programmable dead time on both edges. Gate index 0 is cell leg A, 1 is cell leg B, 2 is the positive bridge leg and 3 is the negative bridge leg.

Top module: `mlpwm_top`

## Requirements
- R1: `level_o` is a 3-bit two's-complement code that always lies in -2..+2. In steady state it equals the number of carriers the held reference exceeds, minus 2.
- R2: Every SAMPLE_DIV clocks the block samples `ref_i`, multiplies it by `mod_idx_i`/256 and saturates the result to -2048..+2047. With `mod_idx_i`=0 the level is 0.
- R3: The held reference plus 2048 is split into four bands of 1024 counts, and band k holds carrier k. The carrier count starts at 0 and rises after reset. It steps by one per sample between 0 and the period, so a carrier sits at the bottom of its band early in a period and near the top after `car_period_i` samples.
- R4: With mode 0 (in phase), every band compares against the direct count.
- R5: With mode 1 (opposed), bands 2 and 3 use the direct count and bands 0 and 1 use the mirrored count (period minus count).
- R6: With mode 2 (alternating), bands 0 and 2 use the direct count and bands 1 and 3 use the mirrored count.
- R7: Mode 3 behaves exactly as mode 0.
- R8: Cell leg A is commanded on for any nonzero magnitude. Cell leg B is commanded on only for magnitude 2. Leg B high is never on unless leg A high is on.
- R9: The positive bridge leg (index 2) is high for positive polarity and the negative leg (index 3) is high for negative polarity. They are never high together. Polarity changes only while the level is 0, so `level_o` never jumps directly between signs.
- R10: On each leg the high and low gates are never on together. After any command change, both stay off for DEAD_CYC clocks before the new side turns on.
- R11: During reset all eight gates are off and `level_o` is 0.
- R12: A `car_period_i` of 0 is treated as 1, so the carrier still toggles every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_i | input | REF_W | Signed reference sample |
| mod_idx_i | input | IDX_W | Modulation index, 256 = unity |
| car_period_i | input | CNT_W | Carrier peak count in samples (half period) |
| disp_mode_i | input | 2 | 0 in phase, 1 opposed, 2 alternating, 3 as 0 |
| level_o | output | 3 | Signed output level -2..+2 |
| gate_hi_o | output | 4 | Upper gates: A, B, positive bridge, negative bridge |
| gate_lo_o | output | 4 | Lower gates, same order |

## Verification
The reference is placed in the middle of each of the four bands under every disposition. This separates direct from mirrored carriers band by band, because a mid-band reference lands on opposite sides of the two carrier shapes early in a period. The same placements are repeated near the carrier peak, where the outcome flips, to confirm that the counter rises over time. Over-range index values at both signs, a zero index and a zero period exercise the saturation and degenerate cases. A step from +2 to -1 shows that the polarity change passes through zero, and a single cell-leg transition measures the dead gap.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;
  localparam int unsigned NUM_SRC  = 2;
  localparam int unsigned NUM_CARR = 2 * NUM_SRC;
  localparam int unsigned NUM_LEGS = 4;

  typedef enum logic [1:0] {
    DISP_INPHASE   = 2'd0,
    DISP_OPPOSED   = 2'd1,
    DISP_ALTERNATE = 2'd2,
    DISP_SPARE     = 2'd3
  } disp_e;

  // True when carrier k uses the mirrored count under disposition m
  function automatic logic carrier_mirrored(input disp_e m, input int unsigned k);
    case (m)
      DISP_OPPOSED:   return (k < NUM_CARR / 2);
      DISP_ALTERNATE: return ((k % 2) == 1);
      default:        return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier #(
  parameter int CNT_W      = 10,
  parameter int SAMPLE_DIV = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] peak_o
);
  localparam int DIV_W = $clog2(SAMPLE_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);

  logic [DIV_W-1:0] div_q, div_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             up_q, up_n;
  logic [CNT_W-1:0] peak;

  assign peak   = (period_i == '0) ? CNT_W'(1) : period_i;
  assign tick_o = (div_q == DIV_LAST);
  assign peak_o = peak;
  assign cnt_o  = (cnt_q > peak) ? peak : cnt_q;

  always_comb begin
    div_n = tick_o ? '0 : div_q + DIV_W'(1);
  end

  always_comb begin
    cnt_n = cnt_q;
    up_n  = up_q;
    if (tick_o) begin
      if (up_q) begin
        if (cnt_q >= peak - CNT_W'(1)) begin
          cnt_n = peak;
          up_n  = 1'b0;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end else begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_n = '0;
          up_n  = 1'b1;
        end else if (cnt_q > peak) begin
          cnt_n = peak;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      div_q <= div_n;
      cnt_q <= cnt_n;
      up_q  <= up_n;
    end
  end
endmodule

// File: rtl/mlpwm_scale.sv
module mlpwm_scale #(
  parameter int REF_W = 12,
  parameter int IDX_W = 9
) (
  input  logic signed [REF_W-1:0] ref_i,
  input  logic        [IDX_W-1:0] idx_i,
  output logic signed [REF_W-1:0] scaled_o
);
  localparam int PW   = REF_W + IDX_W + 1;
  localparam int MAXI = 2 ** (REF_W - 1) - 1;
  localparam int MINI = -(2 ** (REF_W - 1));

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;

  always_comb begin
    prod    = PW'(ref_i) * PW'($signed({1'b0, idx_i}));
    shifted = prod >>> (IDX_W - 1);
    if (shifted > PW'(MAXI))
      scaled_o = REF_W'(MAXI);
    else if (shifted < PW'(MINI))
      scaled_o = REF_W'(MINI);
    else
      scaled_o = shifted[REF_W-1:0];
  end
endmodule

// File: rtl/mlpwm_levelcmp.sv
module mlpwm_levelcmp
  import mlpwm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 10
) (
  input  logic signed [REF_W-1:0]   ref_i,
  input  logic        [CNT_W-1:0]   cnt_i,
  input  logic        [CNT_W-1:0]   peak_i,
  input  disp_e                     mode_i,
  output logic        [NUM_CARR-1:0] exceed_o
);
  localparam int FRAC_W = REF_W - $clog2(NUM_CARR);
  localparam int BAND   = 2 ** FRAC_W;
  localparam int RW     = REF_W + 2;
  localparam int MW     = FRAC_W + CNT_W;

  logic [REF_W-1:0] offs;
  assign offs = {~ref_i[REF_W-1], ref_i[REF_W-2:0]};

  for (genvar k = 0; k < NUM_CARR; k++) begin : g_car
    logic [CNT_W-1:0]  car;
    logic signed [RW-1:0] rel;
    logic [MW-1:0]     lhs, rhs;

    always_comb begin
      car = carrier_mirrored(mode_i, k) ? (peak_i - cnt_i) : cnt_i;
      rel = $signed({2'b00, offs}) - $signed(RW'(k * BAND));
      lhs = MW'(rel[FRAC_W-1:0]) * MW'(peak_i);
      rhs = {car, {FRAC_W{1'b0}}};
      if (rel >= $signed(RW'(BAND)))
        exceed_o[k] = 1'b1;
      else if (rel < $signed(RW'(0)))
        exceed_o[k] = 1'b0;
      else
        exceed_o[k] = (lhs > rhs);
    end
  end
endmodule

// File: rtl/mlpwm_deadband.sv
module mlpwm_deadband #(
  parameter int DEAD_CYC = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  output logic hi_o,
  output logic lo_o
);
  localparam int DW = $clog2(DEAD_CYC + 2);

  logic          cur_q, cur_n;
  logic [DW-1:0] gap_q, gap_n;

  always_comb begin
    cur_n = cur_q;
    gap_n = gap_q;
    if (cmd_i != cur_q) begin
      cur_n = cmd_i;
      gap_n = DW'(DEAD_CYC);
    end else if (gap_q != '0) begin
      gap_n = gap_q - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= 1'b0;
      gap_q <= DW'(DEAD_CYC);
    end else begin
      cur_q <= cur_n;
      gap_q <= gap_n;
    end
  end

  assign hi_o = cur_q  && (gap_q == '0);
  assign lo_o = !cur_q && (gap_q == '0);
endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top
  import mlpwm_pkg::*;
#(
  parameter int REF_W      = 12,
  parameter int IDX_W      = 9,
  parameter int CNT_W      = 10,
  parameter int SAMPLE_DIV = 2000,
  parameter int DEAD_CYC   = 65
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic        [IDX_W-1:0] mod_idx_i,
  input  logic        [CNT_W-1:0] car_period_i,
  input  logic        [1:0]       disp_mode_i,
  output logic signed [2:0]       level_o,
  output logic        [3:0]       gate_hi_o,
  output logic        [3:0]       gate_lo_o
);
  localparam int HIT_W = $clog2(NUM_CARR + 1) + 1;

  // reset: asserted at once, released after two clocks
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic             tick;
  logic [CNT_W-1:0] cnt, peak;

  mlpwm_carrier #(.CNT_W(CNT_W), .SAMPLE_DIV(SAMPLE_DIV)) carrier_i (
    .clk(clk), .rst_n(rst_int_n), .period_i(car_period_i),
    .tick_o(tick), .cnt_o(cnt), .peak_o(peak)
  );

  logic signed [REF_W-1:0] scaled, ref_q, ref_n;

  mlpwm_scale #(.REF_W(REF_W), .IDX_W(IDX_W)) scale_i (
    .ref_i(ref_i), .idx_i(mod_idx_i), .scaled_o(scaled)
  );

  always_comb ref_n = tick ? scaled : ref_q;

  disp_e               mode_w;
  logic [NUM_CARR-1:0] exceed;
  assign mode_w = disp_e'(disp_mode_i);

  mlpwm_levelcmp #(.REF_W(REF_W), .CNT_W(CNT_W)) cmp_i (
    .ref_i(ref_q), .cnt_i(cnt), .peak_i(peak), .mode_i(mode_w), .exceed_o(exceed)
  );

  logic [HIT_W-1:0]        hits;
  logic signed [HIT_W-1:0] lvl_w;
  always_comb begin
    hits = '0;
    for (int k = 0; k < NUM_CARR; k++) hits = hits + HIT_W'(exceed[k]);
    lvl_w = $signed(hits) - $signed(HIT_W'(NUM_SRC));
  end

  // polarity flips only in a cycle where the cell magnitude is forced to zero
  logic       pol_q, pol_n;
  logic [1:0] mag_q, mag_n;
  always_comb begin
    pol_n = pol_q;
    mag_n = mag_q;
    if ((lvl_w > 0 && !pol_q) || (lvl_w < 0 && pol_q)) begin
      pol_n = !pol_q;
      mag_n = 2'd0;
    end else if (lvl_w < 0) begin
      mag_n = 2'(-lvl_w);
    end else begin
      mag_n = 2'(lvl_w);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ref_q <= '0;
      pol_q <= 1'b1;
      mag_q <= 2'd0;
    end else begin
      ref_q <= ref_n;
      pol_q <= pol_n;
      mag_q <= mag_n;
    end
  end

  logic signed [2:0] mag_s;
  assign mag_s   = $signed({1'b0, mag_q});
  assign level_o = pol_q ? mag_s : -mag_s;

  logic [NUM_LEGS-1:0] leg_cmd;
  assign leg_cmd[0] = (mag_q != 2'd0);
  assign leg_cmd[1] = (mag_q == 2'd2);
  assign leg_cmd[2] = pol_q;
  assign leg_cmd[3] = !pol_q;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    mlpwm_deadband #(.DEAD_CYC(DEAD_CYC)) db_i (
      .clk(clk), .rst_n(rst_int_n), .cmd_i(leg_cmd[g]),
      .hi_o(gate_hi_o[g]), .lo_o(gate_lo_o[g])
    );
  end
endmodule

// File: rtl/mlpwm_chk.sv
module mlpwm_chk #(
  parameter int DEAD_CYC = 65
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        gate_hi,
  input logic [3:0]        gate_lo,
  input logic signed [2:0] level
);
  localparam int GW = $clog2(DEAD_CYC + 2);

  for (genvar k = 0; k < 4; k++) begin : g_leg
    logic [GW-1:0] idle_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        idle_q <= '0;
      else if (!gate_hi[k] && !gate_lo[k]) begin
        if (idle_q != GW'(DEAD_CYC + 1)) idle_q <= idle_q + GW'(1);
      end else
        idle_q <= '0;
    end

    // R10
    gate_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi[k] && gate_lo[k]));
    // R10
    hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[k]) |-> (idle_q >= GW'(DEAD_CYC)));
    // R10
    lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo[k]) |-> (idle_q >= GW'(DEAD_CYC)));
  end

  // R1
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= -3'sd2) && (level <= 3'sd2));
  // R9
  pos_via_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level > 0) |-> ($past(level) >= 0));
  // R9
  neg_via_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level < 0) |-> ($past(level) <= 0));
  // R9
  bridge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi[2] && gate_hi[3]));
  // R8
  cell_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hi[1] |-> gate_hi[0]);
endmodule

bind mlpwm_top mlpwm_chk #(.DEAD_CYC(DEAD_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .gate_hi(gate_hi_o), .gate_lo(gate_lo_o), .level(level_o)
);

// File: tb/mlpwm_top_tb_top.sv
module mlpwm_top_tb_top;
  localparam int REF_W = 12, IDX_W = 9, CNT_W = 10, SDIV = 4, DEAD = 3;
  localparam int PER = 200;

  logic clk, rst_n;
  logic signed [REF_W-1:0] ref_s;
  logic [IDX_W-1:0] idx_s;
  logic [CNT_W-1:0] per_s;
  logic [1:0] mode_s;
  logic signed [2:0] level_w;
  logic [3:0] ghi, glo;

  mlpwm_top #(.REF_W(REF_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .SAMPLE_DIV(SDIV), .DEAD_CYC(DEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_s), .mod_idx_i(idx_s), .car_period_i(per_s),
    .disp_mode_i(mode_s), .level_o(level_w), .gate_hi_o(ghi), .gate_lo_o(glo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start(input int md, input int rf, input int ix, input int pr);
    @(negedge clk);
    rst_n  = 1'b0;
    mode_s = 2'(md);
    ref_s  = REF_W'(rf);
    idx_s  = IDX_W'(ix);
    per_s  = CNT_W'(pr);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // early in a period: direct carriers near band bottom, mirrored near top
  localparam int NV = 17;
  localparam int V_MODE [NV] = '{0, 1, 2, 0, 1, 2, 0, 2, 1, 0, 1, 2, 3, 0, 0, 0, 0};
  localparam int V_REF  [NV] = '{512, 512, 512, -512, -512, -512, 1536, 1536, 1536,
                                 -1536, -1536, -1536, -512, 1024, 2047, -2048, 1500};
  localparam int V_IDX  [NV] = '{256, 256, 256, 256, 256, 256, 256, 256, 256,
                                 256, 256, 256, 256, 128, 511, 511, 0};
  localparam int V_EXP  [NV] = '{1, 1, 1, 0, -1, -1, 2, 1, 2, -1, -2, -1, 0, 1, 2, -2, 0};
  // rows: R4 R5 R6 | R4 R5 R6 | R4 R6 R5 | R4 R5 R6 | R7 | R2 index half | R2 sat high | R2 sat low | R2 zero index
  localparam int V_REQ  [NV] = '{4, 5, 6, 4, 5, 6, 4, 6, 5, 4, 5, 6, 7, 2, 2, 2, 2};

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ref_s = '0; idx_s = 9'd256; per_s = CNT_W'(PER); mode_s = 2'd0;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 gates in reset", int'({glo, ghi}), 0);
    check("R11 level in reset", int'(level_w), 0);

    for (int v = 0; v < NV; v++) begin
      logic [3:0] eh, el, mk;
      int lv;
      start(V_MODE[v], V_REF[v], V_IDX[v], PER);
      repeat (40) @(negedge clk);
      lv = V_EXP[v];
      // R1 R3 level = carriers exceeded - 2
      check($sformatf("R%0d level vec %0d", V_REQ[v], v), int'(level_w), lv);
      eh = {lv < 0, lv > 0, (lv == 2 || lv == -2), lv != 0};
      el = ~eh;
      mk = (lv == 0) ? 4'b0011 : 4'b1111;
      // R8 R9 gate pattern
      check($sformatf("R8 gates vec %0d", v), int'({glo & mk, ghi & mk}), int'({el & mk, eh & mk}));
    end

    // R3 near the carrier peak the outcome flips
    start(0, 512, 256, PER);  repeat (800) @(negedge clk);
    check("R3 R4 late in-phase band2", int'(level_w), 0);
    start(1, -512, 256, PER); repeat (800) @(negedge clk);
    check("R3 R5 late opposed band1", int'(level_w), 0);
    start(0, -512, 256, PER); repeat (800) @(negedge clk);
    check("R3 R4 late in-phase band1", int'(level_w), -1);
    start(2, 1536, 256, PER); repeat (800) @(negedge clk);
    check("R3 R6 late alternating band3", int'(level_w), 2);

    // R10 dead gap on cell leg A
    begin
      int gap = 0, ovl = 0;
      bit done = 0;
      start(0, 0, 256, PER);
      repeat (20) @(negedge clk);
      check("R10 leg A low before step", int'(glo[0]), 1);
      ref_s = 12'sd512;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (ghi[0] && glo[0]) ovl++;
        if (!done) begin
          if (!ghi[0] && !glo[0]) gap++;
          else if (ghi[0]) done = 1;
        end
      end
      check("R10 dead gap length", gap, DEAD);
      check("R10 no overlap", ovl, 0);
    end

    // R9 sign change passes through zero
    begin
      int jumps = 0;
      int prev;
      start(0, 1536, 256, PER);
      repeat (40) @(negedge clk);
      prev = int'(level_w);
      ref_s = -12'sd1536;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if ((prev > 0 && int'(level_w) < 0) || (prev < 0 && int'(level_w) > 0)) jumps++;
        prev = int'(level_w);
      end
      check("R9 no direct sign jump", jumps, 0);
      check("R9 final level", int'(level_w), -1);
      check("R9 bridge gates", int'(ghi[3:2]), 2);
    end

    // R12 zero period toggles the carrier each sample
    begin
      int s1 = 0, s0 = 0;
      start(0, 512, 256, 0);
      repeat (10) @(negedge clk);
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (level_w == 3'sd1) s1++;
        if (level_w == 3'sd0) s0++;
      end
      check("R12 level reaches 1", int'(s1 > 0), 1);
      check("R12 level reaches 0", int'(s0 > 0), 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule